// File: doc/BRIEF.md
# Multi-Event Reset Generator

This block raises a reset pulse when a chosen combination of event inputs has been active together for long enough. It has two independent channels. Channel one qualifies up to three event inputs and channel two up to two. Each input has its own enable bit. Only the enabled inputs take part in the match, and a channel matches when every one of them is high in the same cycle.

Timing runs on a slow tick enable, `tick_i`, which the surrounding logic drives one cycle high per time unit. A 3-bit hold code is shared by both channels. A channel starts its reset pulse once the match has been seen on hold code + 1 consecutive ticks. Each channel has its own width code, and the pulse lasts width code + 1 ticks.

After a pulse, a channel stays quiet until its match has gone away at least once. A long-held key combination therefore gives one reset, not a series of them.

Top module: `multi_event_rst_gen`

## Requirements
- R1: Channel one asserts `rst1_o` only when every input of `ev1_i` whose bit in `en1_i` is 1 is high, and an enable bit at 1 means the event is selected.
- R2: Channel two asserts `rst2_o` only when every input of `ev2_i` whose bit in `en2_i` is 1 is high.
- R3: A channel's reset output rises in the cycle after the clock edge that samples `tick_i` high for the (trig_time_i + 1)-th consecutive time with the match present. It never rises earlier.
- R4: If the match is absent at any clock edge before the hold completes, the tick count restarts from zero.
- R5: A channel whose enable mask is all zero never asserts its reset output.
- R6: Once asserted, a reset output stays high for exactly pw_sel + 1 ticks. It falls right after the clock edge that samples the (pw_sel + 1)-th tick of the pulse, and it falls on no other edge.
- R7: After a pulse ends, the channel does not fire again while the match is held. It can fire again only after the match has been absent at one or more clock edges.
- R8: The level of an event input whose enable bit is 0 has no effect on its channel.
- R9: The two channels are independent, so activity on one never changes the other's output.
- R10: While `rst_ni` is low, both reset outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slow time base enable, one cycle per unit |
| trig_time_i | input | 3 | Hold code, hold = code + 1 ticks |
| ev1_i | input | 3 | Channel one event inputs |
| en1_i | input | 3 | Channel one event enables |
| pw1_sel_i | input | 2 | Channel one pulse width code, width = code + 1 ticks |
| ev2_i | input | 2 | Channel two event inputs |
| en2_i | input | 2 | Channel two event enables |
| pw2_sel_i | input | 2 | Channel two pulse width code |
| rst1_o | output | 1 | Channel one reset pulse |
| rst2_o | output | 1 | Channel two reset pulse |

## Verification
The hardest state to reach is a hold that breaks partway through. The match must vanish for a single clock edge after some ticks have already been counted, and then come back. The bench does this by dropping the events for one cycle after two ticks with a hold code of three. It then counts ticks from the restore and expects the full four. The lock-out after a pulse is handled the same way. Events stay held across many ticks with no new pulse expected, then a one-cycle release must re-arm the channel.

// File: rtl/rst_gen_pkg.sv
package rst_gen_pkg;
  typedef enum logic [1:0] {
    CH_ARM    = 2'd0,
    CH_PULSE  = 2'd1,
    CH_LOCKED = 2'd2
  } ch_state_e;
endpackage

// File: rtl/rst_evt_qual.sv
module rst_evt_qual #(
  parameter int N_EV = 3
) (
  input  logic [N_EV-1:0] ev_i,
  input  logic [N_EV-1:0] en_i,
  output logic            match_o
);
  logic [N_EV-1:0] hit;

  for (genvar g = 0; g < N_EV; g++) begin : g_ev
    assign hit[g] = ev_i[g] | ~en_i[g];
  end

  // an empty mask must never match
  assign match_o = (|en_i) & (&hit);
endmodule

// File: rtl/rst_chan_fsm.sv
module rst_chan_fsm
  import rst_gen_pkg::*;
#(
  parameter int TT_W = 3,
  parameter int PW_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            match_i,
  input  logic [TT_W-1:0] trig_time_i,
  input  logic [PW_W-1:0] pw_sel_i,
  output logic            rst_o
);
  ch_state_e       state_q;
  logic [TT_W-1:0] hold_q;
  logic [PW_W-1:0] wid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CH_ARM;
      hold_q  <= '0;
      wid_q   <= '0;
    end else begin
      unique case (state_q)
        CH_ARM: begin
          if (!match_i) begin
            hold_q <= '0;
          end else if (tick_i) begin
            if (hold_q >= trig_time_i) begin
              state_q <= CH_PULSE;
              hold_q  <= '0;
              wid_q   <= '0;
            end else begin
              hold_q <= hold_q + 1'b1;
            end
          end
        end
        CH_PULSE: begin
          if (tick_i) begin
            if (wid_q >= pw_sel_i) state_q <= CH_LOCKED;
            else                   wid_q   <= wid_q + 1'b1;
          end
        end
        CH_LOCKED: begin
          if (!match_i) state_q <= CH_ARM;
        end
        default: state_q <= CH_ARM;
      endcase
    end
  end

  assign rst_o = (state_q == CH_PULSE);

  a_r3_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_o) |-> $past(tick_i) && $past(match_i));

  a_r6_fall_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o && !tick_i |=> rst_o);

  a_r7_locked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CH_LOCKED) |=> !rst_o);

  a_r4_no_fire_without_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_o && !match_i |=> !rst_o);
endmodule

// File: rtl/multi_event_rst_gen.sv
module multi_event_rst_gen #(
  parameter int N_EV1 = 3,
  parameter int N_EV2 = 2,
  parameter int TT_W  = 3,
  parameter int PW_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [TT_W-1:0]  trig_time_i,
  input  logic [N_EV1-1:0] ev1_i,
  input  logic [N_EV1-1:0] en1_i,
  input  logic [PW_W-1:0]  pw1_sel_i,
  input  logic [N_EV2-1:0] ev2_i,
  input  logic [N_EV2-1:0] en2_i,
  input  logic [PW_W-1:0]  pw2_sel_i,
  output logic             rst1_o,
  output logic             rst2_o
);
  logic match1, match2;

  rst_evt_qual #(.N_EV(N_EV1)) u_qual1 (
    .ev_i(ev1_i), .en_i(en1_i), .match_o(match1)
  );

  rst_evt_qual #(.N_EV(N_EV2)) u_qual2 (
    .ev_i(ev2_i), .en_i(en2_i), .match_o(match2)
  );

  rst_chan_fsm #(.TT_W(TT_W), .PW_W(PW_W)) u_ch1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .match_i(match1),
    .trig_time_i(trig_time_i), .pw_sel_i(pw1_sel_i), .rst_o(rst1_o)
  );

  rst_chan_fsm #(.TT_W(TT_W), .PW_W(PW_W)) u_ch2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .match_i(match2),
    .trig_time_i(trig_time_i), .pw_sel_i(pw2_sel_i), .rst_o(rst2_o)
  );

  a_r5_empty_mask1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en1_i == '0) && !rst1_o |=> !rst1_o);

  a_r5_empty_mask2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en2_i == '0) && !rst2_o |=> !rst2_o);

  a_r1_partial_match1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst1_o && ((ev1_i & en1_i) != en1_i) |=> !rst1_o);

  a_r2_partial_match2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst2_o && ((ev2_i & en2_i) != en2_i) |=> !rst2_o);
endmodule

// File: tb/multi_event_rst_gen_tb.sv
module multi_event_rst_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [2:0] trig_time_i = '0;
  logic [2:0] ev1_i = '0, en1_i = '0;
  logic [1:0] ev2_i = '0, en2_i = '0;
  logic [1:0] pw1_sel_i = '0, pw2_sel_i = '0;
  logic       rst1_o, rst2_o;

  int checks = 0;
  int fails  = 0;
  int div_cnt = 0;

  multi_event_rst_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .trig_time_i(trig_time_i),
    .ev1_i(ev1_i), .en1_i(en1_i), .pw1_sel_i(pw1_sel_i),
    .ev2_i(ev2_i), .en2_i(en2_i), .pw2_sel_i(pw2_sel_i),
    .rst1_o(rst1_o), .rst2_o(rst2_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(negedge clk_i) begin
    tick_i  <= (div_cnt == TICK_DIV-1);
    div_cnt <= (div_cnt == TICK_DIV-1) ? 0 : div_cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic get_rst(input int ch);
    return (ch == 1) ? rst1_o : rst2_o;
  endfunction

  task automatic expect_fire(input int ch, input int nt, input string tag);
    int n = 0;
    bit seen = 0;
    for (int c = 0; c < 400 && !seen; c++) begin
      logic tk;
      @(posedge clk_i);
      tk = tick_i;
      #1;
      if (tk) n++;
      if (get_rst(ch)) seen = 1;
    end
    check(seen && n == nt, tag, seen ? n : -1, nt);
  endtask

  task automatic expect_width(input int ch, input int pw, input string tag);
    int n = 0;
    bit done = 0;
    for (int c = 0; c < 400 && !done; c++) begin
      logic tk;
      @(posedge clk_i);
      tk = tick_i;
      #1;
      if (tk) n++;
      if (!get_rst(ch)) done = 1;
    end
    check(done && n == pw + 1, tag, done ? n : -1, pw + 1);
  endtask

  task automatic expect_quiet(input int ch, input int nt, input string tag);
    int n = 0;
    bit hit = 0;
    while (n < nt) begin
      logic tk;
      @(posedge clk_i);
      tk = tick_i;
      #1;
      if (tk) n++;
      if (get_rst(ch)) hit = 1;
    end
    check(!hit, tag, hit, 0);
  endtask

  task automatic idle_all();
    @(negedge clk_i);
    ev1_i = '0;
    ev2_i = '0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic t_reset();
    #(CLK_PERIOD*3 + 1);
    check(rst1_o == 0 && rst2_o == 0, "R10 outputs low in reset", {rst1_o, rst2_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_ch1_basic();
    @(negedge clk_i);
    trig_time_i = 3'd2;
    pw1_sel_i = 2'd1;
    en1_i = 3'b111;
    ev1_i = 3'b111;
    expect_fire(1, 3, "R1 R3 ch1 fires after code+1 ticks");
    check(rst2_o == 0, "R9 ch2 unaffected by ch1", rst2_o, 0);
    expect_width(1, 1, "R6 ch1 width code+1 ticks");
    expect_quiet(1, 10, "R7 no refire while held");
    @(negedge clk_i);
    ev1_i = 3'b000;
    @(negedge clk_i);
    ev1_i = 3'b111;
    expect_fire(1, 3, "R7 refires after release");
    expect_width(1, 1, "R6 second pulse width");
    idle_all();
  endtask

  task automatic t_restart();
    @(negedge clk_i);
    trig_time_i = 3'd3;
    pw1_sel_i = 2'd0;
    en1_i = 3'b111;
    ev1_i = 3'b111;
    begin
      int n = 0;
      while (n < 2) begin
        @(posedge clk_i);
        if (tick_i) n++;
      end
    end
    check(rst1_o == 0, "R4 not fired before drop", rst1_o, 0);
    @(negedge clk_i);
    ev1_i = 3'b110;
    @(negedge clk_i);
    ev1_i = 3'b111;
    expect_fire(1, 4, "R4 count restarts after drop");
    expect_width(1, 0, "R6 width code 0 is one tick");
    idle_all();
  endtask

  task automatic t_mask();
    @(negedge clk_i);
    trig_time_i = 3'd1;
    pw1_sel_i = 2'd2;
    en1_i = 3'b011;
    ev1_i = 3'b100;
    expect_quiet(1, 6, "R8 disabled event alone no fire");
    @(negedge clk_i);
    ev1_i = 3'b011;
    expect_fire(1, 2, "R8 disabled event low ignored");
    expect_width(1, 2, "R6 width code 2");
    idle_all();
    @(negedge clk_i);
    ev1_i = 3'b001;
    expect_quiet(1, 6, "R1 partial match no fire");
    idle_all();
  endtask

  task automatic t_empty();
    @(negedge clk_i);
    trig_time_i = 3'd0;
    en1_i = 3'b000;
    en2_i = 2'b00;
    ev1_i = 3'b111;
    ev2_i = 2'b11;
    expect_quiet(1, 8, "R5 ch1 empty mask never fires");
    expect_quiet(2, 2, "R5 ch2 empty mask never fires");
    idle_all();
  endtask

  task automatic t_ch2();
    @(negedge clk_i);
    trig_time_i = 3'd0;
    pw2_sel_i = 2'd3;
    en2_i = 2'b11;
    ev2_i = 2'b01;
    expect_quiet(2, 5, "R2 ch2 partial match no fire");
    @(negedge clk_i);
    ev2_i = 2'b11;
    expect_fire(2, 1, "R2 R3 ch2 fires after one tick");
    check(rst1_o == 0, "R9 ch1 unaffected by ch2", rst1_o, 0);
    expect_width(2, 3, "R6 ch2 width code 3");
    idle_all();
  endtask

  initial begin
    t_reset();
    t_ch1_basic();
    t_restart();
    t_mask();
    t_empty();
    t_ch2();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule